// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Block

This block holds the control and status registers of a network controller. The host sees only two 16-bit words. One word is a register-select latch. The other is a data window onto whichever of four internal registers the latch names:

- the main status/command word;
- the low part of a 24-bit initialization-block address;
- the high part of that address;
- a three-bit bus-configuration register.

The select latch keeps its value, so software can read or write the same register many times without selecting it again.

The status word gathers sticky event flags, which the rest of the controller raises with single-cycle strobes. It derives two read-only summaries from them: an error summary and an interrupt summary. The interrupt output is driven when the interrupt summary is set and the host has enabled interrupts. Command bits written by the host become single-cycle pulses towards the controller (initialize, start, stop, transmit demand). A stop also clears the run state and the bus configuration.

Top module: `nic_csr_port`

## Requirements
- R1: A write with `host_port_sel`=1 stores `host_wdata[1:0]` as the register select (0 status, 1 address low, 2 address high, 3 bus config). The select reads back on bits 1:0 of the select word, with zeros above. It keeps its value through any number of data-word accesses.
- R2: Status bits 14:8 are sticky event flags in the order BABL, CERR, MISS, MERR, RINT, TINT, IDON (bit 14 to bit 8), each set by `ev_set[6:0]` (bit 6 = BABL … bit 0 = IDON). Writing 1 to a flag's bit clears it and writing 0 leaves it. A strobe in the same cycle as a clearing write leaves the flag set.
- R3: Status bit 15 reads as the OR of BABL, CERR, MISS and MERR.
- R4: Status bit 7 reads as the OR of BABL, MISS, MERR, RINT, TINT and IDON. CERR does not contribute.
- R5: `irq` is high exactly when status bit 7 and the interrupt-enable bit (status bit 6, host-writable) are both 1.
- R6: Writing 1 to status bit 0 (init), 1 (start), 2 (stop) or 3 (transmit demand) raises the matching `cmd_*` output for exactly the one cycle after the write. These bits read as 0.
- R7: A start write sets receive-on (bit 5) and transmit-on (bit 4). A stop write clears bits 6, 5 and 4 and the bus configuration, and it takes precedence over start or an interrupt-enable value written alongside it.
- R8: The address-low register stores bits 15:1 and reads bit 0 as 0. The address-high register stores bits 7:0 and reads bits 15:8 as 0. `init_addr` is {high, low}.
- R9: The bus-config register stores bits 2:0 (bit 2 byte swap, bit 1 address-latch polarity, bit 0 byte control), reads bits 15:3 as 0, and drives `bus_cfg`.
- R10: During and after reset every register is 0, no command pulse is driven and `irq` is low.
- R11: Status bits 15, 7, 5 and 4 ignore host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_port_sel | input | 1 | 0 selects the data word (byte offset 0), 1 the select word (byte offset 2) |
| host_wr | input | 1 | Host write strobe for the addressed word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read value of the addressed word (combinational) |
| ev_set | input | 7 | Event strobes: BABL, CERR, MISS, MERR, RINT, TINT, IDON (bit 6 to 0) |
| cmd_init | output | 1 | Initialize pulse |
| cmd_start | output | 1 | Start pulse |
| cmd_stop | output | 1 | Stop pulse |
| cmd_tx_demand | output | 1 | Transmit-demand pulse |
| irq | output | 1 | Interrupt request |
| init_addr | output | 24 | Initialization-block address |
| bus_cfg | output | 3 | Bus configuration bits |

## Verification
Every write and every event strobe lands at the clock edge that samples it. From the following cycle on, `host_rdata` (combinational on `host_port_sel` and state), the summaries, `irq`, `init_addr` and `bus_cfg` show the new value. A command pulse is high in exactly that one following cycle and low in the next. The bench drives inputs on the falling edge, advances its behavioural model on the rising edge, and compares every output shortly after each falling edge, when the outputs hold their post-edge values. Directed reads follow the same rule.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int CSR_W = 16;
  localparam int EV_N  = 7;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_IADR_LO = 2'd1,
    SEL_IADR_HI = 2'd2,
    SEL_BUSCFG  = 2'd3
  } csr_sel_e;

  // event index inside the sticky vector (== status bit - 8)
  localparam int EV_BABL = 6;
  localparam int EV_CERR = 5;
  localparam int EV_MISS = 4;
  localparam int EV_MERR = 3;
  localparam int EV_RINT = 2;
  localparam int EV_TINT = 1;
  localparam int EV_IDON = 0;

  localparam logic [EV_N-1:0] ERR_MASK  = 7'b1111000;
  localparam logic [EV_N-1:0] INTR_MASK = 7'b1011111;

  // command bit positions in the status word
  localparam int CB_INIT = 0;
  localparam int CB_STRT = 1;
  localparam int CB_STOP = 2;
  localparam int CB_TDMD = 3;
  localparam int CB_N    = 4;
endpackage

// File: rtl/nic_csr_rst_sync.sv
module nic_csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nic_csr_sel.sv
module nic_csr_sel
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output csr_sel_e         sel_q
);
  csr_sel_e sel_d;

  always_comb begin
    sel_d = sel_q;
    if (sel_we) sel_d = csr_sel_e'(sel_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= SEL_STATUS;
    else if (sel_we) sel_q <= sel_d;
  end
endmodule

// File: rtl/nic_csr_status.sv
module nic_csr_status
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EV_N-1:0]  wr_clr,
  input  logic             wr_inea,
  input  logic [CB_N-1:0]  wr_cmd,
  input  logic [EV_N-1:0]  ev_set,
  output logic [CSR_W-1:0] status_rd,
  output logic [CB_N-1:0]  cmd_pulse,
  output logic             stop_now,
  output logic             irq
);
  logic [EV_N-1:0] flag_q;
  logic            inea_q, inea_d, run_en;
  logic            rxon_q, rxon_d, txon_q, txon_d;
  logic [CB_N-1:0] cmd_d;
  logic            start_now, err_sum, intr_sum;

  assign stop_now  = wr_en & wr_cmd[CB_STOP];
  assign start_now = wr_en & wr_cmd[CB_STRT];

  genvar gi;
  generate
    for (gi = 0; gi < EV_N; gi++) begin : g_flag
      logic flag_d, flag_en;
      always_comb begin
        flag_en = ev_set[gi] | (wr_en & wr_clr[gi]);
        flag_d  = ev_set[gi];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q[gi] <= 1'b0;
        else if (flag_en) flag_q[gi] <= flag_d;
      end
    end
  endgenerate

  always_comb begin
    run_en = wr_en;
    inea_d = inea_q;
    rxon_d = rxon_q;
    txon_d = txon_q;
    if (wr_en) inea_d = wr_inea;
    if (start_now) begin
      rxon_d = 1'b1;
      txon_d = 1'b1;
    end
    if (stop_now) begin
      inea_d = 1'b0;
      rxon_d = 1'b0;
      txon_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inea_q <= 1'b0;
      rxon_q <= 1'b0;
      txon_q <= 1'b0;
    end else if (run_en) begin
      inea_q <= inea_d;
      rxon_q <= rxon_d;
      txon_q <= txon_d;
    end
  end

  always_comb cmd_d = wr_en ? wr_cmd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_pulse <= '0;
    else        cmd_pulse <= cmd_d;
  end

  assign err_sum  = |(flag_q & ERR_MASK);
  assign intr_sum = |(flag_q & INTR_MASK);
  assign irq      = intr_sum & inea_q;

  assign status_rd = {err_sum, flag_q, intr_sum, inea_q, rxon_q, txon_q, {CB_N{1'b0}}};
endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg
  import nic_csr_pkg::*;
#(
  parameter int INIT_ADDR_W = 24,
  parameter int CFG_W       = 3,
  localparam int HI_W       = INIT_ADDR_W - CSR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lo_we,
  input  logic                   hi_we,
  input  logic                   cfg_we,
  input  logic                   stop_clr,
  input  logic [CSR_W-1:0]       wdata,
  output logic [CSR_W-1:0]       lo_rd,
  output logic [CSR_W-1:0]       hi_rd,
  output logic [CSR_W-1:0]       cfg_rd,
  output logic [INIT_ADDR_W-1:0] init_addr,
  output logic [CFG_W-1:0]       bus_cfg
);
  logic [CSR_W-1:1] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_we) lo_q <= wdata[CSR_W-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_we) hi_q <= wdata[HI_W-1:0];
  end

  always_comb begin
    cfg_en = cfg_we | stop_clr;
    cfg_d  = stop_clr ? '0 : wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign lo_rd     = {lo_q, 1'b0};
  assign hi_rd     = {{(CSR_W-HI_W){1'b0}}, hi_q};
  assign cfg_rd    = {{(CSR_W-CFG_W){1'b0}}, cfg_q};
  assign init_addr = {hi_q, lo_q, 1'b0};
  assign bus_cfg   = cfg_q;
endmodule

// File: rtl/nic_csr_port.sv
module nic_csr_port
  import nic_csr_pkg::*;
#(
  parameter int INIT_ADDR_W = 24,
  parameter int CFG_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_port_sel,
  input  logic                   host_wr,
  input  logic [CSR_W-1:0]       host_wdata,
  output logic [CSR_W-1:0]       host_rdata,
  input  logic [EV_N-1:0]        ev_set,
  output logic                   cmd_init,
  output logic                   cmd_start,
  output logic                   cmd_stop,
  output logic                   cmd_tx_demand,
  output logic                   irq,
  output logic [INIT_ADDR_W-1:0] init_addr,
  output logic [CFG_W-1:0]       bus_cfg
);
  logic             rst_sync_n;
  csr_sel_e         sel_q;
  logic             data_we, sel_we;
  logic [CSR_W-1:0] status_rd, lo_rd, hi_rd, cfg_rd, data_rd;
  logic [CB_N-1:0]  cmd_pulse;
  logic             stop_now;

  nic_csr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign data_we = host_wr & ~host_port_sel;
  assign sel_we  = host_wr &  host_port_sel;

  nic_csr_sel u_sel (
    .clk(clk), .rst_n(rst_sync_n), .sel_we(sel_we),
    .sel_wdata(host_wdata[SEL_W-1:0]), .sel_q(sel_q)
  );

  nic_csr_status u_status (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(data_we && sel_q == SEL_STATUS),
    .wr_clr(host_wdata[8+EV_N-1:8]),
    .wr_inea(host_wdata[6]),
    .wr_cmd(host_wdata[CB_N-1:0]),
    .ev_set(ev_set),
    .status_rd(status_rd), .cmd_pulse(cmd_pulse),
    .stop_now(stop_now), .irq(irq)
  );

  nic_csr_cfg #(.INIT_ADDR_W(INIT_ADDR_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .lo_we(data_we && sel_q == SEL_IADR_LO),
    .hi_we(data_we && sel_q == SEL_IADR_HI),
    .cfg_we(data_we && sel_q == SEL_BUSCFG),
    .stop_clr(stop_now), .wdata(host_wdata),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .cfg_rd(cfg_rd),
    .init_addr(init_addr), .bus_cfg(bus_cfg)
  );

  always_comb begin
    unique case (sel_q)
      SEL_STATUS:  data_rd = status_rd;
      SEL_IADR_LO: data_rd = lo_rd;
      SEL_IADR_HI: data_rd = hi_rd;
      default:     data_rd = cfg_rd;
    endcase
  end

  assign host_rdata = host_port_sel ? {{(CSR_W-SEL_W){1'b0}}, sel_q} : data_rd;

  assign cmd_init      = cmd_pulse[CB_INIT];
  assign cmd_start     = cmd_pulse[CB_STRT];
  assign cmd_stop      = cmd_pulse[CB_STOP];
  assign cmd_tx_demand = cmd_pulse[CB_TDMD];
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk
  import nic_csr_pkg::*;
#(
  parameter int INIT_ADDR_W = 24,
  parameter int CFG_W       = 3
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   host_port_sel,
  input logic                   host_wr,
  input logic [CSR_W-1:0]       host_wdata,
  input logic [EV_N-1:0]        ev_set,
  input logic [SEL_W-1:0]       sel_q,
  input logic [CSR_W-1:0]       status_rd,
  input logic                   cmd_start,
  input logic                   cmd_stop,
  input logic                   irq,
  input logic [INIT_ADDR_W-1:0] init_addr,
  input logic [CFG_W-1:0]       bus_cfg
);
  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_wr && host_port_sel) |=> $stable(sel_q));

  // R2
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ev_set) |=> ((status_rd[14:8] & $past(ev_set)) == $past(ev_set)));

  // R3
  err_from_cerr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_set[EV_CERR] |=> status_rd[15]);

  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_rd[6] && ev_set[EV_TINT] && !host_wr) |=> irq);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && !host_port_sel && sel_q == 2'd0 && host_wdata[CB_STRT]) |=> cmd_start);

  // R6
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_start && !(host_wr && !host_port_sel && sel_q == 2'd0)) |=> !cmd_start);

  // R7
  stop_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stop |-> (status_rd[6:4] == 3'b000 && bus_cfg == '0));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_wr |=> $stable(init_addr));
endmodule

bind nic_csr_port nic_csr_chk #(.INIT_ADDR_W(INIT_ADDR_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_port_sel(host_port_sel),
  .host_wr(host_wr), .host_wdata(host_wdata), .ev_set(ev_set),
  .sel_q(sel_q), .status_rd(status_rd), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .irq(irq), .init_addr(init_addr), .bus_cfg(bus_cfg)
);

// File: tb/test_nic_csr_port.sv
module test_nic_csr_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_port_sel, host_wr;
  logic [15:0] host_wdata, host_rdata;
  logic [6:0]  ev_set;
  logic        cmd_init, cmd_start, cmd_stop, cmd_tx_demand, irq;
  logic [23:0] init_addr;
  logic [2:0]  bus_cfg;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nic_csr_port i_nic_csr_port (
    .clk(clk), .rst_n(rst_n), .host_port_sel(host_port_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_set(ev_set),
    .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_tx_demand(cmd_tx_demand), .irq(irq), .init_addr(init_addr), .bus_cfg(bus_cfg)
  );

  // behavioural reference model
  int          m_sel;
  logic [6:0]  m_flags;
  bit          m_inea, m_rxon, m_txon;
  logic [15:0] m_lo;
  logic [7:0]  m_hi;
  logic [2:0]  m_cfg;
  logic [3:0]  m_cmd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_flags = '0; m_inea = 0; m_rxon = 0; m_txon = 0;
      m_lo = '0; m_hi = '0; m_cfg = '0; m_cmd = '0;
    end else begin
      bit wd, w0;
      wd = host_wr && !host_port_sel;
      w0 = wd && (m_sel == 0);
      m_cmd = w0 ? host_wdata[3:0] : 4'b0;
      m_flags = (m_flags & ~(w0 ? host_wdata[14:8] : 7'b0)) | ev_set;
      if (w0) begin
        m_inea = host_wdata[6];
        if (host_wdata[1]) begin m_rxon = 1; m_txon = 1; end
        if (host_wdata[2]) begin m_rxon = 0; m_txon = 0; m_inea = 0; m_cfg = '0; end
      end
      if (wd && m_sel == 1) m_lo = host_wdata & 16'hFFFE;
      if (wd && m_sel == 2) m_hi = host_wdata[7:0];
      if (wd && m_sel == 3) m_cfg = host_wdata[2:0];
      if (host_wr && host_port_sel) m_sel = int'(host_wdata[1:0]);
    end
  end

  function automatic bit m_intr();
    return m_flags[6] | m_flags[4] | m_flags[3] | m_flags[2] | m_flags[1] | m_flags[0];
  endfunction

  function automatic logic [15:0] m_status();
    bit err;
    err = |m_flags[6:3];
    return {err, m_flags, m_intr(), m_inea, m_rxon, m_txon, 4'b0};
  endfunction

  function automatic logic [15:0] m_rdata();
    if (host_port_sel) return 16'(m_sel);
    case (m_sel)
      0: return m_status();
      1: return m_lo;
      2: return {8'h00, m_hi};
      default: return {13'b0, m_cfg};
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      string rt;
      rt = host_port_sel ? "R1" : (m_sel == 0 ? "R2" : (m_sel == 3 ? "R9" : "R8"));
      check(rt, "rdata", 32'(host_rdata), 32'(m_rdata()));
      check("R6", "commands", 32'({cmd_tx_demand, cmd_stop, cmd_start, cmd_init}), 32'(m_cmd));
      check("R5", "irq", 32'(irq), 32'(m_inea & m_intr()));
      check("R8", "init_addr", 32'(init_addr), 32'({m_hi, m_lo}));
      check("R9", "bus_cfg", 32'(bus_cfg), 32'(m_cfg));
    end
  end

  task automatic drive(bit ps, bit wr, logic [15:0] wd, logic [6:0] ev);
    @(negedge clk);
    host_port_sel = ps; host_wr = wr; host_wdata = wd; ev_set = ev;
  endtask

  task automatic idle_to(bit ps);
    drive(ps, 0, 16'h0, 7'h0);
    #2;
  endtask

  task automatic wr_sel(int s); drive(1, 1, 16'(s), 7'h0); endtask
  task automatic wr_dat(logic [15:0] d); drive(0, 1, d, 7'h0); endtask

  initial begin
    #(10 * 20000);
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; host_port_sel = 0; host_wr = 0; host_wdata = '0; ev_set = '0;
    repeat (3) @(negedge clk);
    #2;
    // R10 reset state
    check("R10", "status at reset", 32'(host_rdata), 0);
    check("R10", "irq at reset", 32'(irq), 0);
    check("R10", "cmds at reset", 32'({cmd_init, cmd_start, cmd_stop, cmd_tx_demand}), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 address low, R1 select holds
    wr_sel(1); wr_dat(16'h1235);
    idle_to(0); check("R8", "addr low bit0 zero", 32'(host_rdata), 32'h1234);
    idle_to(0); check("R1", "reread without reselect", 32'(host_rdata), 32'h1234);
    idle_to(1); check("R1", "select readback", 32'(host_rdata), 1);
    wr_sel(2); wr_dat(16'hABCD);
    idle_to(0); check("R8", "addr high upper zero", 32'(host_rdata), 32'h00CD);
    check("R8", "init_addr", 32'(init_addr), 32'hCD1234);
    // R9 bus config
    wr_sel(3); wr_dat(16'hFFFF);
    idle_to(0); check("R9", "bus cfg width", 32'(host_rdata), 32'h0007);
    check("R9", "bus_cfg out", 32'(bus_cfg), 7);

    // R2/R4 event and interrupt summary
    wr_sel(0); drive(0, 0, 16'h0, 7'b0000001);
    idle_to(0); check("R4", "IDON feeds INTR", 32'(host_rdata), 32'h0180);
    check("R5", "irq masked", 32'(irq), 0);
    wr_dat(16'h0040);
    idle_to(0); check("R5", "irq enabled", 32'(irq), 1);
    drive(0, 0, 16'h0, 7'b0100000);
    idle_to(0); check("R3", "CERR feeds ERR", 32'(host_rdata), 32'hA1C0);
    wr_dat(16'h0140);
    idle_to(0); check("R4", "CERR alone no INTR", 32'(host_rdata), 32'hA040);
    check("R5", "irq drops", 32'(irq), 0);
    wr_dat(16'h0040);
    idle_to(0); check("R2", "write 0 keeps flag", 32'(host_rdata), 32'hA040);
    wr_dat(16'h80B0);
    idle_to(0); check("R11", "read-only bits", 32'(host_rdata), 32'hA000);
    drive(0, 1, 16'h2000, 7'b0100000);
    idle_to(0); check("R2", "set beats clear", 32'(host_rdata), 32'hA000);

    // R6/R7 start
    wr_dat(16'h0042);
    idle_to(0); check("R6", "start pulse", 32'(cmd_start), 1);
    check("R7", "start sets run", 32'(host_rdata), 32'hA070);
    idle_to(0); check("R6", "start pulse ends", 32'(cmd_start), 0);
    // R7 stop wins over inea and start
    wr_dat(16'h0046);
    idle_to(0); check("R6", "stop pulse", 32'(cmd_stop), 1);
    check("R7", "stop clears run", 32'(host_rdata), 32'hA000);
    check("R7", "stop clears bus cfg", 32'(bus_cfg), 0);
    wr_dat(16'h0009);
    idle_to(0); check("R6", "init+tdmd pulses", 32'({cmd_init, cmd_tx_demand}), 32'b11);
    idle_to(0); check("R6", "pulses end", 32'({cmd_init, cmd_tx_demand}), 0);

    // mixed stimulus, compared every cycle
    for (int i = 0; i < 600; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      drive(($urandom % 4) == 0, ($urandom % 3) == 0, d, 7'($urandom) & 7'($urandom));
    end
    idle_to(0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule